// File: doc/BRIEF.md
# Battery Capacity Tracking Counters

This block holds the capacity bookkeeping of a rechargeable-battery fuel gauge. Upstream logic delivers single-cycle pulses for charge, discharge and self-discharge that are already corrected for rate and temperature. The block turns them into an available-capacity count, a discharge count and a learned full-capacity reference. It also counts valid charges, so that it can flag a reference that has gone stale. A host reads the register outputs, and a display stage uses the available count against the full reference.

The learning path is a three-state machine. In LRN_IDLE no learning cycle is open. LRN_ARMED means the pack was seen full and the discharge count restarted from zero. LRN_QUAL means a qualified discharge to empty has finished and a transfer is pending. The transitions are as follows. T_ARM goes from IDLE to ARMED on a full or calibration event, and T_REARM repeats it while already ARMED. T_DISARM goes from ARMED to IDLE when a valid charge arrives before the pack reaches empty. T_QUALIFY goes from ARMED to QUAL at end-of-discharge when all conditions hold, and T_REJECT goes from ARMED to IDLE when they do not. T_LEARN goes from QUAL to IDLE on the next valid charge and copies the discharge count into the reference. T_REQUAL goes from QUAL to ARMED if a full or calibration event comes first.

Top module: `cap_track_top`

## Requirements
- R1: While `rst_n` is low, or in the cycle after `init_req` is sampled high, the block clears `nac`, `dcr` and `cpi`, loads `lmd` from `pfc_init`, sets `ci`, and clears `vdq`, `edv` and `vq`.
- R2: A charge pulse raises `nac` by one unless `nac` equals `lmd`. A discharge or self-discharge pulse lowers `nac` by one unless `nac` is zero.
- R3: Only one event acts per cycle, in this order of precedence: end-of-discharge, trickle event, charge, discharge, self-discharge. The events below the one that acts are ignored in that cycle.
- R4: A discharge pulse always increments `dcr`. A self-discharge pulse increments `dcr` only while `nac` is non-zero. `dcr` stops at FFFFh.
- R5: An end-of-discharge event forces `nac` to zero, sets `edv`, and clears `vq` and `vdq`. `edv` stays set until the next valid charge.
- R6: A valid charge is the second of two `nac` increments with no discharge, self-discharge or end-of-discharge event between them. It sets `vq` and clears `edv`. It also increments `cpi`, which saturates at 255, and `ci` is set once `cpi` exceeds 64.
- R7: `vdq` is set and `dcr` is cleared when a charge pulse leaves `nac` equal to `lmd`. The same happens on a trickle event with `nac` > T80, where T80 = L/2 + L/4 + L/32 + L/64, each term floored, and L = `lmd`.
- R8: On a trickle event with T80 < `nac` <= T85, `nac` becomes T85, where T85 = L/2 + L/4 + L/16 + L/32 + L/128. If `nac` is above T85, or at or below T80, `nac` does not change.
- R9: An end-of-discharge event qualifies the discharge only when three conditions hold. `vdq` must be set. The self-discharge pulses counted into `dcr` since `vdq` was set must be at most P/16 + P/32 + P/256 + P/512, where P is the programmed full count. And `temp_neg` must be low.
- R10: The first valid charge after a qualified discharge loads `lmd` with the larger of `dcr` and L − L/4, and clears `cpi` and `ci`. Any other valid charge leaves `lmd` unchanged.
- R11: A valid charge while `vdq` is set clears `vdq`, unless that same charge pulse makes `nac` equal `lmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Synchronous re-initialisation request |
| pfc_init | input | 16 | Programmed full count, loaded at reset |
| chg_pulse | input | 1 | Compensated charge unit |
| dsg_pulse | input | 1 | Compensated discharge unit |
| sdc_pulse | input | 1 | Self-discharge unit |
| eod_evt | input | 1 | End-of-discharge detected |
| trickle_evt | input | 1 | Fast-to-trickle transition detected |
| temp_neg | input | 1 | Temperature below 0 °C |
| nac | output | 16 | Available capacity count |
| lmd | output | 16 | Learned full reference |
| dcr | output | 16 | Discharge count |
| cpi | output | 8 | Valid-charge count since last learning |
| vdq | output | 1 | Discharge cycle eligible for learning |
| ci | output | 1 | Reference stale |
| edv | output | 1 | End-of-discharge latched |
| vq | output | 1 | Valid charge seen since last end-of-discharge |

## Verification
A wrong learning state does not show at once. It shows as an `lmd` that changes, or fails to change, on the valid charge after an end-of-discharge event. That can be thousands of cycles after the cause, so the bench checks `lmd` at exactly that point for each qualifying condition. A wrong half-charge count or wrong event precedence shows on `nac`, `dcr` or `vdq` in the very next cycle, and the stimulus table checks those ports after every step.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        LRN_IDLE  = 2'd0,
        LRN_ARMED = 2'd1,
        LRN_QUAL  = 2'd2
    } lrn_state_t;
endpackage

// File: rtl/cap_thresh.sv
module cap_thresh #(
    parameter int W = 16
) (
    input  logic [W-1:0] lmd,
    input  logic [W-1:0] pfc,
    output logic [W-1:0] t75,
    output logic [W-1:0] t80,
    output logic [W-1:0] t85,
    output logic [W-1:0] sd_lim
);
    // shift-and-add fractions, each term floored
    assign t75    = lmd - (lmd >> 2);
    assign t80    = (lmd >> 1) + (lmd >> 2) + (lmd >> 5) + (lmd >> 6);
    assign t85    = (lmd >> 1) + (lmd >> 2) + (lmd >> 4) + (lmd >> 5) + (lmd >> 7);
    assign sd_lim = (pfc >> 4) + (pfc >> 5) + (pfc >> 8) + (pfc >> 9);
endmodule

// File: rtl/cap_learn_fsm.sv
module cap_learn_fsm
    import cap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_req,
    input  logic         eod_go,
    input  logic         arm_req,
    input  logic         valid_chg,
    input  logic         sdc_cnt,
    input  logic         temp_neg,
    input  logic [W-1:0] sd_lim,
    output logic         vdq,
    output logic         xfer_now,
    output logic         arm_now
);
    localparam logic [W-1:0] ACC_MAX = '1;

    lrn_state_t state_q, state_d;
    logic [W-1:0] sdc_acc_q;
    logic qual_ok;

    assign qual_ok  = (sdc_acc_q <= sd_lim) && !temp_neg;
    assign xfer_now = (state_q == LRN_QUAL) && valid_chg;
    assign arm_now  = arm_req && !xfer_now;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LRN_IDLE: begin
                if (arm_req) state_d = LRN_ARMED;                  // T_ARM
            end
            LRN_ARMED: begin
                if (eod_go)         state_d = qual_ok ? LRN_QUAL   // T_QUALIFY
                                                      : LRN_IDLE;  // T_REJECT
                else if (arm_req)   state_d = LRN_ARMED;           // T_REARM
                else if (valid_chg) state_d = LRN_IDLE;            // T_DISARM
            end
            LRN_QUAL: begin
                if (valid_chg)    state_d = LRN_IDLE;              // T_LEARN
                else if (arm_req) state_d = LRN_ARMED;             // T_REQUAL
            end
            default: state_d = LRN_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= LRN_IDLE;
        else if (init_req) state_q <= LRN_IDLE;
        else               state_q <= state_d;
    end

    // outputs and self-discharge window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vdq       <= 1'b0;
            sdc_acc_q <= '0;
        end else if (init_req) begin
            vdq       <= 1'b0;
            sdc_acc_q <= '0;
        end else begin
            vdq <= (state_d == LRN_ARMED);
            if (arm_now)
                sdc_acc_q <= '0;
            else if (state_q == LRN_ARMED && sdc_cnt && sdc_acc_q != ACC_MAX)
                sdc_acc_q <= sdc_acc_q + 1'b1;
        end
    end

    p_vdq_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eod_go && !init_req) |=> !vdq);

    p_disarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vdq && valid_chg && !arm_req && !eod_go && !init_req) |=> !vdq);
endmodule

// File: rtl/cap_regs.sv
module cap_regs #(
    parameter int W        = 16,
    parameter int CPI_W    = 8,
    parameter int CI_LIMIT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic [W-1:0]     pfc_init,
    input  logic             eod_go,
    input  logic             trk_go,
    input  logic             chg_go,
    input  logic             dsg_go,
    input  logic             sdc_go,
    input  logic             arm_now,
    input  logic             xfer_now,
    input  logic [W-1:0]     t75,
    input  logic [W-1:0]     t80,
    input  logic [W-1:0]     t85,
    output logic [W-1:0]     pfc_q,
    output logic [W-1:0]     nac_q,
    output logic [W-1:0]     lmd_q,
    output logic [W-1:0]     dcr_q,
    output logic [CPI_W-1:0] cpi_q,
    output logic             ci_q,
    output logic             edv_q,
    output logic             vq_q,
    output logic             valid_chg,
    output logic             arm_req,
    output logic             sdc_cnt
);
    localparam logic [W-1:0]     DCR_MAX = '1;
    localparam logic [CPI_W-1:0] CPI_MAX = '1;
    localparam logic [CPI_W-1:0] CI_THR  = CPI_W'(CI_LIMIT);

    logic [W-1:0]     nac_d, lmd_d, dcr_d, nac_inc;
    logic [CPI_W-1:0] cpi_d;
    logic             ci_d, edv_d, vq_d, half_q, half_d;
    logic             room, full_hit, trk_hit;

    assign nac_inc   = nac_q + 1'b1;
    assign room      = nac_q < lmd_q;
    assign valid_chg = chg_go && room && half_q;
    assign full_hit  = chg_go && (!room || nac_inc == lmd_q);
    assign trk_hit   = trk_go && (nac_q > t80);
    assign arm_req   = full_hit || trk_hit;
    assign sdc_cnt   = sdc_go && (nac_q != '0);

    always_comb begin
        nac_d  = nac_q;
        lmd_d  = lmd_q;
        dcr_d  = dcr_q;
        cpi_d  = cpi_q;
        ci_d   = ci_q;
        edv_d  = edv_q;
        vq_d   = vq_q;
        half_d = half_q;
        if (eod_go) begin
            nac_d  = '0;
            edv_d  = 1'b1;
            vq_d   = 1'b0;
            half_d = 1'b0;
        end else if (trk_go) begin
            if (trk_hit && nac_q <= t85) nac_d = t85;
        end else if (chg_go) begin
            if (room) begin
                nac_d  = nac_inc;
                half_d = !half_q;
            end
            if (valid_chg) begin
                edv_d = 1'b0;
                vq_d  = 1'b1;
                if (cpi_q != CPI_MAX) cpi_d = cpi_q + 1'b1;
                if (cpi_d > CI_THR)   ci_d  = 1'b1;
            end
        end else if (dsg_go) begin
            if (nac_q != '0)      nac_d = nac_q - 1'b1;
            if (dcr_q != DCR_MAX) dcr_d = dcr_q + 1'b1;
            half_d = 1'b0;
        end else if (sdc_go) begin
            if (sdc_cnt) begin
                nac_d = nac_q - 1'b1;
                if (dcr_q != DCR_MAX) dcr_d = dcr_q + 1'b1;
            end
            half_d = 1'b0;
        end
        if (arm_now) dcr_d = '0;
        if (xfer_now) begin
            lmd_d = (dcr_q > t75) ? dcr_q : t75;
            cpi_d = '0;
            ci_d  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || init_req) begin
            pfc_q  <= pfc_init;
            nac_q  <= '0;
            lmd_q  <= pfc_init;
            dcr_q  <= '0;
            cpi_q  <= '0;
            ci_q   <= 1'b1;
            edv_q  <= 1'b0;
            vq_q   <= 1'b0;
            half_q <= 1'b0;
        end else begin
            nac_q  <= nac_d;
            lmd_q  <= lmd_d;
            dcr_q  <= dcr_d;
            cpi_q  <= cpi_d;
            ci_q   <= ci_d;
            edv_q  <= edv_d;
            vq_q   <= vq_d;
            half_q <= half_d;
        end
    end

    p_nac_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nac_q <= lmd_q);

    p_dcr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dcr_q == DCR_MAX && !arm_now && !init_req) |=> dcr_q == DCR_MAX);

    p_eod_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eod_go && !init_req) |=> (nac_q == '0 && edv_q));

    p_cpi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpi_q == CPI_MAX && !xfer_now && !init_req) |=> cpi_q == CPI_MAX);

    p_lmd_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_now && !init_req) |=> lmd_q >= $past(t75));
endmodule

// File: rtl/cap_track_top.sv
module cap_track_top #(
    parameter int W        = 16,
    parameter int CPI_W    = 8,
    parameter int CI_LIMIT = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic [W-1:0]     pfc_init,
    input  logic             chg_pulse,
    input  logic             dsg_pulse,
    input  logic             sdc_pulse,
    input  logic             eod_evt,
    input  logic             trickle_evt,
    input  logic             temp_neg,
    output logic [W-1:0]     nac,
    output logic [W-1:0]     lmd,
    output logic [W-1:0]     dcr,
    output logic [CPI_W-1:0] cpi,
    output logic             vdq,
    output logic             ci,
    output logic             edv,
    output logic             vq
);
    logic eod_go, trk_go, chg_go, dsg_go, sdc_go;
    logic arm_req, arm_now, xfer_now, valid_chg, sdc_cnt;
    logic [W-1:0] pfc_q, t75, t80, t85, sd_lim;

    // event precedence: eod > trickle > charge > discharge > self-discharge
    assign eod_go = eod_evt;
    assign trk_go = trickle_evt && !eod_go;
    assign chg_go = chg_pulse && !eod_go && !trickle_evt;
    assign dsg_go = dsg_pulse && !chg_pulse && !eod_go && !trickle_evt;
    assign sdc_go = sdc_pulse && !dsg_pulse && !chg_pulse && !eod_go && !trickle_evt;

    cap_thresh #(.W(W)) thr_i (
        .lmd(lmd), .pfc(pfc_q), .t75(t75), .t80(t80), .t85(t85), .sd_lim(sd_lim)
    );

    cap_learn_fsm #(.W(W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .eod_go(eod_go),
        .arm_req(arm_req), .valid_chg(valid_chg), .sdc_cnt(sdc_cnt),
        .temp_neg(temp_neg), .sd_lim(sd_lim), .vdq(vdq),
        .xfer_now(xfer_now), .arm_now(arm_now)
    );

    cap_regs #(.W(W), .CPI_W(CPI_W), .CI_LIMIT(CI_LIMIT)) regs_i (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .pfc_init(pfc_init),
        .eod_go(eod_go), .trk_go(trk_go), .chg_go(chg_go), .dsg_go(dsg_go),
        .sdc_go(sdc_go), .arm_now(arm_now), .xfer_now(xfer_now),
        .t75(t75), .t80(t80), .t85(t85), .pfc_q(pfc_q),
        .nac_q(nac), .lmd_q(lmd), .dcr_q(dcr), .cpi_q(cpi), .ci_q(ci),
        .edv_q(edv), .vq_q(vq), .valid_chg(valid_chg), .arm_req(arm_req),
        .sdc_cnt(sdc_cnt)
    );
endmodule

// File: tb/cap_track_top_tb_top.sv
`timescale 1ns/1ps
module cap_track_top_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, init_req = 1'b0;
    logic [15:0] pfc_init = 16'd20;
    logic chg = 0, dsg = 0, sdc = 0, eod = 0, trk = 0, tneg = 0;
    logic [15:0] nac, lmd, dcr;
    logic [7:0] cpi;
    logic vdq, ci, edv, vq;
    int checks = 0, errors = 0;
    bit done = 0;

    cap_track_top dut_i (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .pfc_init(pfc_init),
        .chg_pulse(chg), .dsg_pulse(dsg), .sdc_pulse(sdc), .eod_evt(eod),
        .trickle_evt(trk), .temp_neg(tneg), .nac(nac), .lmd(lmd), .dcr(dcr),
        .cpi(cpi), .vdq(vdq), .ci(ci), .edv(edv), .vq(vq)
    );

    // {rep[8], ctl{chg,dsg,sdc,eod,trk,tneg}[6], nac[16], dcr[16], lmd[16], vdq, edv}
    localparam int NV = 19;
    localparam logic [63:0] TBL [NV] = '{
        {8'd20, 6'b100000, 16'd20, 16'd0,  16'd20, 1'b1, 1'b0},
        {8'd1,  6'b100000, 16'd20, 16'd0,  16'd20, 1'b1, 1'b0},
        {8'd5,  6'b010000, 16'd15, 16'd5,  16'd20, 1'b1, 1'b0},
        {8'd1,  6'b001000, 16'd14, 16'd6,  16'd20, 1'b1, 1'b0},
        {8'd14, 6'b010000, 16'd0,  16'd20, 16'd20, 1'b1, 1'b0},
        {8'd2,  6'b001000, 16'd0,  16'd20, 16'd20, 1'b1, 1'b0},
        {8'd3,  6'b010000, 16'd0,  16'd23, 16'd20, 1'b1, 1'b0},
        {8'd1,  6'b000100, 16'd0,  16'd23, 16'd20, 1'b0, 1'b1},
        {8'd2,  6'b100000, 16'd2,  16'd23, 16'd23, 1'b0, 1'b0},
        {8'd21, 6'b100000, 16'd23, 16'd0,  16'd23, 1'b1, 1'b0},
        {8'd1,  6'b000010, 16'd23, 16'd0,  16'd23, 1'b1, 1'b0},
        {8'd10, 6'b010000, 16'd13, 16'd10, 16'd23, 1'b1, 1'b0},
        {8'd1,  6'b100000, 16'd14, 16'd10, 16'd23, 1'b1, 1'b0},
        {8'd1,  6'b100000, 16'd15, 16'd10, 16'd23, 1'b0, 1'b0},
        {8'd15, 6'b010000, 16'd0,  16'd25, 16'd23, 1'b0, 1'b0},
        {8'd1,  6'b000100, 16'd0,  16'd25, 16'd23, 1'b0, 1'b1},
        {8'd2,  6'b100000, 16'd2,  16'd25, 16'd23, 1'b0, 1'b0},
        {8'd15, 6'b100000, 16'd17, 16'd25, 16'd23, 1'b0, 1'b0},
        {8'd1,  6'b000010, 16'd17, 16'd0,  16'd23, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [5:0] ctl, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            {chg, dsg, sdc, eod, trk, tneg} = ctl;
        end
        @(negedge clk);
        {chg, dsg, sdc, eod, trk, tneg} = '0;
    endtask

    task automatic chk_reset(input string tag, input logic [15:0] p);
        chk({tag, " nac"}, nac, 0);
        chk({tag, " dcr"}, dcr, 0);
        chk({tag, " cpi"}, cpi, 0);
        chk({tag, " lmd"}, lmd, p);
        chk({tag, " ci"}, ci, 1);
        chk({tag, " flags"}, {vdq, edv, vq}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset("R1 power-on", 16'd20);

        for (int v = 0; v < NV; v++) begin
            drive(TBL[v][55:50], int'(TBL[v][63:56]));
            chk($sformatf("table step %0d nac (R2 R3 R8)", v), nac, TBL[v][49:34]);
            chk($sformatf("table step %0d dcr (R4 R7)", v), dcr, TBL[v][33:18]);
            chk($sformatf("table step %0d lmd (R9 R10)", v), lmd, TBL[v][17:2]);
            chk($sformatf("table step %0d vdq (R7 R11)", v), vdq, TBL[v][1]);
            chk($sformatf("table step %0d edv (R5)", v), edv, TBL[v][0]);
            if (v == 7)  chk("R5 vq cleared at eod", vq, 0);
            if (v == 8)  chk("R6 vq set on valid charge", vq, 1);
        end

        // re-initialise with a larger full count
        @(negedge clk);
        pfc_init = 16'd1000; init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
        chk_reset("R1 init_req", 16'd1000);

        drive(6'b100000, 800);
        chk("R6 cpi saturates", cpi, 255);
        chk("R6 ci stays set", ci, 1);
        drive(6'b000010, 1);
        chk("R8 trickle raises nac", nac, 850);
        chk("R7 trickle arms vdq", vdq, 1);
        chk("R7 trickle clears dcr", dcr, 0);

        drive(6'b010000, 54);
        drive(6'b000010, 1);
        chk("R8 trickle at T80 ignored nac", nac, 796);
        chk("R7 trickle at T80 ignored dcr", dcr, 54);

        drive(6'b001000, 98);
        chk("R4 self-discharge counted", dcr, 152);
        drive(6'b000100, 1);
        drive(6'b100000, 2);
        chk("R9 too much self-discharge lmd", lmd, 1000);

        drive(6'b100000, 998);
        drive(6'b010000, 10);
        drive(6'b000101, 1);
        drive(6'b100000, 2);
        chk("R9 cold eod lmd", lmd, 1000);

        drive(6'b100000, 998);
        chk("R7 full arms", vdq, 1);
        drive(6'b010000, 10);
        drive(6'b000100, 1);
        drive(6'b100000, 2);
        chk("R10 lmd clamped to 75%", lmd, 750);
        chk("R10 cpi cleared", cpi, 0);
        chk("R10 ci cleared", ci, 0);
        chk("R10 dcr kept", dcr, 10);

        drive(6'b100000, 128);
        chk("R6 cpi at 64", cpi, 64);
        chk("R6 ci not yet", ci, 0);
        drive(6'b100000, 2);
        chk("R6 cpi at 65", cpi, 65);
        chk("R6 ci set above 64", ci, 1);

        drive(6'b110000, 1);
        chk("R3 charge beats discharge nac", nac, 133);
        chk("R3 charge beats discharge dcr", dcr, 10);
        drive(6'b011000, 1);
        chk("R3 discharge beats self nac", nac, 132);
        chk("R3 discharge beats self dcr", dcr, 11);
        drive(6'b100100, 1);
        chk("R3 eod beats charge nac", nac, 0);
        chk("R3 eod beats charge edv", edv, 1);

        drive(6'b010000, 65530);
        chk("R4 dcr saturates", dcr, 16'hFFFF);
        chk("R2 nac floor", nac, 0);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset("R1 second reset", 16'd1000);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule